// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit data pointers and one control byte for an 8051-style processor core. The core reads and writes the pointer bytes and the control byte through a byte-wide special-function-register port. Reads return data in the same cycle. The selected pointer drives a 16-bit address output that the core uses for external data and code accesses.

The core's decoder raises a one-cycle strobe for each pointer-related instruction. There are five: code read through the pointer, external read, external write, pointer increment, and load-immediate. The unit updates the pointers and the select bit on the clock edge that samples the strobe. Each pointer has its own step direction. Two control bits let the data-move instructions step the active pointer and switch to the other pointer without extra instructions. A block copy can therefore alternate between a source pointer and a destination pointer with no overhead.

Top module: `dptr_pair_unit`

## Requirements
- R1: Reset clears both pointers and the control byte. Control bits 3:1 always read 0, and writes to them have no effect.
- R2: The register map is as follows. Address 82h is pointer 0 low byte and 83h is its high byte. Address 84h is pointer 1 low byte and 85h is its high byte. Address 86h is the control byte. Any other address reads 00h. A read returns data combinationally in the same cycle.
- R3: Control bit 0 selects the active pointer (0 selects pointer 0, 1 selects pointer 1). `ptr_addr` shows the active pointer. Strobes change only the active pointer.
- R4: The increment strobe always steps the active pointer, whatever bit 4 holds. The step adds 1 when the pointer's direction bit is 0 and subtracts 1 when it is 1. Bit 6 is the direction bit for pointer 0 and bit 7 is the direction bit for pointer 1.
- R5: When control bit 4 is 1, the code-read, external-read and external-write strobes step the active pointer in its direction. When bit 4 is 0, these strobes leave both pointers unchanged.
- R6: When control bit 5 is 1, any of the five strobes inverts bit 0. If the same strobe also steps or loads a pointer, that change applies to the pointer that was active before the inversion.
- R7: The load strobe writes all 16 bits of `load_val` into the active pointer in one cycle.
- R8: Pointer arithmetic wraps modulo 65536: FFFFh plus 1 gives 0000h, and 0000h minus 1 gives FFFFh.
- R9: A register write in the same cycle as a strobe takes priority for the byte it writes. A write to a pointer byte overrides only that byte. A write to the control byte overrides that cycle's toggle.
- R10: A cycle with no strobe and no register write leaves all state unchanged. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational |
| op_movc | input | 1 | Code read through pointer |
| op_xrd | input | 1 | External read through pointer |
| op_xwr | input | 1 | External write through pointer |
| op_inc | input | 1 | Pointer increment instruction |
| op_load | input | 1 | Load pointer with immediate |
| load_val | input | 16 | Immediate value for load |
| ptr_addr | output | 16 | Active pointer value |

## Verification
The checker tests these properties on every cycle:
- the reserved control bits stay zero;
- the strobes are mutually exclusive;
- the inactive pointer holds unless it is written;
- an idle cycle holds all state;
- an increment steps the pointer in its configured direction;
- a load lands in the active pointer;
- data moves with bit 4 clear leave the pointers alone;
- the toggle bit flips the select bit.

Some behaviour can only be shown by the bench's scenarios: interleaved copy sequences that alternate pointers, wrap at both ends of the address range, the per-byte outcome when a register write collides with a strobe, and the register read map.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 2 * BYTE_W;
  localparam int unsigned N_PTR  = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  typedef struct packed {
    logic       dir1;
    logic       dir0;
    logic       tsl;
    logic       aid;
    logic [2:0] rsvd;
    logic       sel;
  } ctl_t;

  typedef struct packed {
    logic movc;
    logic xrd;
    logic xwr;
    logic inc;
    logic load;
  } op_t;

  function automatic ptr_t ptr_step(input ptr_t v, input logic down);
    return down ? (v - ptr_t'(1)) : (v + ptr_t'(1));
  endfunction

  function automatic ctl_t ctl_from_byte(input byte_t b);
    ctl_t c;
    c = ctl_t'(b);
    c.rsvd = '0;
    return c;
  endfunction
endpackage

// File: rtl/dptr_op_dec.sv
module dptr_op_dec
  import dptr_pkg::*;
(
  input  op_t  op,
  input  logic aid,
  output logic step_req,
  output logic load_req,
  output logic any_op
);
  logic data_move;

  always_comb begin
    data_move = op.movc | op.xrd | op.xwr;
    step_req  = op.inc | (aid & data_move);
    load_req  = op.load;
    any_op    = data_move | op.inc | op.load;
  end
endmodule

// File: rtl/dptr_ctl_reg.sv
module dptr_ctl_reg
  import dptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wdata,
  input  logic  any_op,
  output ctl_t  q,
  output logic  tog_fire
);
  ctl_t nxt;

  always_comb begin
    tog_fire = any_op & q.tsl & ~wr_en;
    nxt = q;
    if (wr_en) nxt = ctl_from_byte(wdata);
    else if (tog_fire) nxt.sel = ~q.sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lo_we,
  input  logic  hi_we,
  input  byte_t wbyte,
  input  logic  load_en,
  input  ptr_t  load_val,
  input  logic  step_en,
  input  logic  step_down,
  output ptr_t  q
);
  ptr_t nxt;

  always_comb begin
    nxt = q;
    if (load_en)      nxt = load_val;
    else if (step_en) nxt = ptr_step(q, step_down);
    if (lo_we) nxt[BYTE_W-1:0]     = wbyte;
    if (hi_we) nxt[PTR_W-1:BYTE_W] = wbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dptr_pkg::*;
#(
  parameter byte_t ADDR_P0_LO = 8'h82,
  parameter byte_t ADDR_P0_HI = 8'h83,
  parameter byte_t ADDR_P1_LO = 8'h84,
  parameter byte_t ADDR_P1_HI = 8'h85,
  parameter byte_t ADDR_CTL   = 8'h86
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        op_movc,
  input  logic        op_xrd,
  input  logic        op_xwr,
  input  logic        op_inc,
  input  logic        op_load,
  input  logic [15:0] load_val,
  output logic [15:0] ptr_addr
);
  op_t  op;
  ctl_t ctl_q;
  logic step_req, load_req, any_op, tog_fire;
  logic ctl_wr;
  logic [N_PTR-1:0] lo_we, hi_we, dir_vec, is_active;
  ptr_t ptr_q [N_PTR];
  ptr_t p0_q, p1_q;
  byte_t lo_addr [N_PTR];
  byte_t hi_addr [N_PTR];

  assign op = '{movc: op_movc, xrd: op_xrd, xwr: op_xwr, inc: op_inc, load: op_load};

  assign lo_addr[0] = ADDR_P0_LO;
  assign hi_addr[0] = ADDR_P0_HI;
  assign lo_addr[1] = ADDR_P1_LO;
  assign hi_addr[1] = ADDR_P1_HI;

  assign ctl_wr  = sfr_wr && (sfr_addr == ADDR_CTL);
  assign dir_vec = {ctl_q.dir1, ctl_q.dir0};

  dptr_op_dec u_dec (
    .op       (op),
    .aid      (ctl_q.aid),
    .step_req (step_req),
    .load_req (load_req),
    .any_op   (any_op)
  );

  dptr_ctl_reg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr),
    .wdata    (sfr_wdata),
    .any_op   (any_op),
    .q        (ctl_q),
    .tog_fire (tog_fire)
  );

  for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
    assign is_active[i] = (ctl_q.sel == 1'(i));
    assign lo_we[i]     = sfr_wr && (sfr_addr == lo_addr[i]);
    assign hi_we[i]     = sfr_wr && (sfr_addr == hi_addr[i]);

    dptr_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .lo_we     (lo_we[i]),
      .hi_we     (hi_we[i]),
      .wbyte     (sfr_wdata),
      .load_en   (load_req & is_active[i]),
      .load_val  (load_val),
      .step_en   (step_req & is_active[i]),
      .step_down (dir_vec[i]),
      .q         (ptr_q[i])
    );
  end

  assign p0_q     = ptr_q[0];
  assign p1_q     = ptr_q[1];
  assign ptr_addr = ctl_q.sel ? p1_q : p0_q;

  always_comb begin
    sfr_rdata = '0;
    if (sfr_addr == ADDR_P0_LO) sfr_rdata = p0_q[BYTE_W-1:0];
    if (sfr_addr == ADDR_P0_HI) sfr_rdata = p0_q[PTR_W-1:BYTE_W];
    if (sfr_addr == ADDR_P1_LO) sfr_rdata = p1_q[BYTE_W-1:0];
    if (sfr_addr == ADDR_P1_HI) sfr_rdata = p1_q[PTR_W-1:BYTE_W];
    if (sfr_addr == ADDR_CTL)   sfr_rdata = ctl_q;
  end
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sfr_wr,
  input logic        op_movc,
  input logic        op_xrd,
  input logic        op_xwr,
  input logic        op_inc,
  input logic        op_load,
  input logic [15:0] load_val,
  input logic [15:0] p0_q,
  input logic [15:0] p1_q,
  input logic [7:0]  ctl_q
);
  logic moves, anyop;
  assign moves = op_movc | op_xrd | op_xwr;
  assign anyop = moves | op_inc | op_load;

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3:1] == 3'b000);

  a_r10_ops_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_movc, op_xrd, op_xwr, op_inc, op_load}));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyop && !sfr_wr) |=> ($stable(p0_q) && $stable(p1_q) && $stable(ctl_q)));

  a_r3_inactive_p1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_wr && !ctl_q[0]) |=> $stable(p1_q));

  a_r3_inactive_p0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_wr && ctl_q[0]) |=> $stable(p0_q));

  a_r4_inc_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inc && !sfr_wr && !ctl_q[0]) |=>
      (p0_q == ($past(ctl_q[6]) ? $past(p0_q) - 16'd1 : $past(p0_q) + 16'd1)));

  a_r5_no_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
    (moves && !ctl_q[4] && !sfr_wr) |=> ($stable(p0_q) && $stable(p1_q)));

  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (anyop && ctl_q[5] && !sfr_wr) |=> (ctl_q[0] != $past(ctl_q[0])));

  a_r7_load_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_load && !sfr_wr && ctl_q[0]) |=> (p1_q == $past(load_val)));
endmodule

bind dptr_pair_unit dptr_pair_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sfr_wr   (sfr_wr),
  .op_movc  (op_movc),
  .op_xrd   (op_xrd),
  .op_xwr   (op_xwr),
  .op_inc   (op_inc),
  .op_load  (op_load),
  .load_val (load_val),
  .p0_q     (p0_q),
  .p1_q     (p1_q),
  .ctl_q    (ctl_q)
);

// File: tb/dptr_pair_unit_tb.sv
module dptr_pair_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        op_movc = 1'b0, op_xrd = 1'b0, op_xwr = 1'b0, op_inc = 1'b0, op_load = 1'b0;
  logic [15:0] load_val = 16'h0000;
  logic [15:0] ptr_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dptr_pair_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .op_movc(op_movc),
    .op_xrd(op_xrd), .op_xwr(op_xwr), .op_inc(op_inc), .op_load(op_load),
    .load_val(load_val), .ptr_addr(ptr_addr)
  );

  // kinds: 0 idle, 1 register write, 2 code read, 3 ext read, 4 ext write, 5 inc, 6 load
  typedef struct packed {
    logic [3:0]  kind;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] exp_addr;
    logic [7:0]  exp_ctl;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd6, 8'h00, 16'h1234, 16'h1234, 8'h00},  // R7 load p0
    '{4'd1, 8'h86, 16'h0001, 16'h0000, 8'h01},  // R3 select p1
    '{4'd6, 8'h00, 16'hABCD, 16'hABCD, 8'h01},  // R7 load p1
    '{4'd1, 8'h86, 16'h0031, 16'hABCD, 8'h31},  // tsl+aid on
    '{4'd3, 8'h00, 16'h0000, 16'h1234, 8'h30},  // R5 R6 p1 steps, toggle
    '{4'd4, 8'h00, 16'h0000, 16'hABCE, 8'h31},  // R5 R6 p0 steps
    '{4'd2, 8'h00, 16'h0000, 16'h1235, 8'h30},  // R5 R6 code read
    '{4'd1, 8'h86, 16'h00C0, 16'h1235, 8'hC0},  // both dirs down
    '{4'd5, 8'h00, 16'h0000, 16'h1234, 8'hC0},  // R4 inc with aid off, down
    '{4'd3, 8'h00, 16'h0000, 16'h1234, 8'hC0},  // R5 no auto step
    '{4'd1, 8'h86, 16'h00FF, 16'hABCF, 8'hF1},  // R1 rsvd masked
    '{4'd5, 8'h00, 16'h0000, 16'h1234, 8'hF0},  // R4 R6 p1 down, toggle
    '{4'd1, 8'h82, 16'h0000, 16'h1200, 8'hF0},  // R2 write p0 low
    '{4'd1, 8'h83, 16'h0000, 16'h0000, 8'hF0},  // R2 write p0 high
    '{4'd4, 8'h00, 16'h0000, 16'hABCE, 8'hF1},  // R8 0000-1 -> FFFF in p0
    '{4'd6, 8'h00, 16'h0000, 16'hFFFF, 8'hF0},  // R6 R7 load p1, toggle
    '{4'd1, 8'h86, 16'h0010, 16'hFFFF, 8'h10},  // aid only, up
    '{4'd3, 8'h00, 16'h0000, 16'h0000, 8'h10}   // R8 FFFF+1 -> 0000
  };

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic clear_inputs();
    sfr_wr = 1'b0; sfr_wdata = 8'h00; load_val = 16'h0000;
    op_movc = 1'b0; op_xrd = 1'b0; op_xwr = 1'b0; op_inc = 1'b0; op_load = 1'b0;
  endtask

  // drives at a falling edge, returns at the next falling edge after the update
  task automatic do_cycle(input logic [3:0] kind, input logic wr, input logic [7:0] addr, input logic [15:0] d);
    sfr_wr = wr; sfr_addr = addr; sfr_wdata = d[7:0]; load_val = d;
    op_movc = (kind == 4'd2); op_xrd = (kind == 4'd3); op_xwr = (kind == 4'd4);
    op_inc = (kind == 4'd5); op_load = (kind == 4'd6);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic read_reg(input logic [7:0] addr, output logic [7:0] val);
    sfr_addr = addr;
    #1;
    val = sfr_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "reset ptr_addr", ptr_addr, 16'h0000);
    for (int a = 8'h82; a <= 8'h86; a++) begin
      read_reg(8'(a), rv);
      check("R1", "reset reg", {8'h00, rv}, 16'h0000);
    end

    for (int i = 0; i < NV; i++) begin
      do_cycle(VEC[i].kind == 4'd1 ? 4'd0 : VEC[i].kind, VEC[i].kind == 4'd1, VEC[i].addr, VEC[i].data);
      #1;
      check("R3", $sformatf("vec %0d ptr_addr", i), ptr_addr, VEC[i].exp_addr);
      read_reg(8'h86, rv);
      check("R6", $sformatf("vec %0d ctl", i), {8'h00, rv}, {8'h00, VEC[i].exp_ctl});
    end

    // state now: p0=0000, p1=0000, ctl=10
    // R2 pointer 1 byte writes and readback
    do_cycle(4'd0, 1'b1, 8'h84, 16'h005A);
    do_cycle(4'd0, 1'b1, 8'h85, 16'h00A5);
    read_reg(8'h84, rv); check("R2", "p1 low", {8'h00, rv}, 16'h005A);
    read_reg(8'h85, rv); check("R2", "p1 high", {8'h00, rv}, 16'h00A5);
    read_reg(8'h87, rv); check("R2", "unmapped 87", {8'h00, rv}, 16'h0000);
    read_reg(8'h81, rv); check("R2", "unmapped 81", {8'h00, rv}, 16'h0000);

    // R10 idle cycles hold state
    do_cycle(4'd0, 1'b0, 8'h00, 16'h0000);
    do_cycle(4'd0, 1'b0, 8'h00, 16'h0000);
    #1; check("R10", "idle ptr_addr", ptr_addr, 16'h0000);
    read_reg(8'h85, rv); check("R10", "idle p1 high", {8'h00, rv}, 16'h00A5);

    // R1 reserved bits ignore writes
    do_cycle(4'd0, 1'b1, 8'h86, 16'h000E);
    read_reg(8'h86, rv); check("R1", "rsvd write", {8'h00, rv}, 16'h0000);

    // R9 pointer byte write collides with increment: low byte wins, high from step
    do_cycle(4'd5, 1'b1, 8'h82, 16'h0077);
    #1; check("R9", "collide p0", ptr_addr, 16'h0077);

    // R9 control write collides with toggle: written value wins
    do_cycle(4'd0, 1'b1, 8'h86, 16'h0020);
    do_cycle(4'd5, 1'b1, 8'h86, 16'h0021);
    read_reg(8'h86, rv); check("R9", "collide ctl", {8'h00, rv}, 16'h0021);
    read_reg(8'h82, rv); check("R9", "collide p0 stepped", {8'h00, rv}, 16'h0078);
    #1; check("R3", "addr shows p1", ptr_addr, 16'hA55A);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1; check("R1", "reset ptr_addr again", ptr_addr, 16'h0000);
    read_reg(8'h84, rv); check("R1", "reset p1 low", {8'h00, rv}, 16'h0000);
    read_reg(8'h86, rv); check("R1", "reset ctl", {8'h00, rv}, 16'h0000);

    finish_run();
  end
endmodule